// File: doc/BRIEF.md
# SMBus Bus-State and SCL-Low Timeout Monitor

This block sits beside a two-wire SMBus port and follows what happens on the SCL and SDA lines. It brings the raw line levels into its own clock domain through a two-flop synchronizer. It then recognises START and STOP conditions and keeps a bus-busy flag. A transfer in progress sets the flag. A STOP clears it, and so does a long enough idle period counted in ticks from one of four timer-overflow sources.

A second counter watches for SCL being held low for too long. The counter is loaded from a 16-bit reload value while SCL is high and counts clock cycles while SCL is low. When it overflows, it sets a sticky interrupt flag that software clears with a strobe. The counter can also run as two independent byte halves. The block also passes slave-event interrupts through a software-controlled inhibit, and it exports an extended SDA setup/hold enable for a downstream timing stage.

Software reaches the block through one configuration byte. The byte is written with a strobe and read back continuously.

Top module: `smbus_line_monitor`

## Requirements
- R1: After reset, the configuration byte reads 0x00, and bus_busy, bus_free, tmo_irq, ext_hold and slv_irq are all 0.
- R2: The configuration byte has this layout: bit0 enable, bit1 slave inhibit, bit2 busy (read-only), bit3 extended hold, bit4 SCL-low timeout enable, bit5 free-timeout enable, bits7:6 tick select. A write with cfg_wr stores every bit except bit2. Bit2 always reads as the current bus_busy value.
- R3: While enabled, SDA falling while SCL stays high is a START. It gives one start_det pulse and sets bus_busy.
- R4: While enabled, SDA rising while SCL stays high is a STOP. It gives one stop_det pulse and clears bus_busy. SDA changing while SCL is low is neither a START nor a STOP.
- R5: With free-timeout enabled, once SCL and SDA have both been high for 11 selected ticks, bus_busy clears and bus_free goes to 1. After 10 such ticks, neither has changed. bus_free stays at 1 until either line goes low. A low on either line restarts the count.
- R6: The tick select value picks the tick source: 00 is tick_t0, 01 is tick_t1, 10 is tick_t2h and 11 is tick_t2l. Ticks on sources that are not selected have no effect.
- R7: With enable at 0, no START or STOP is detected, bus_busy stays at 0, and the timeout counter never raises tmo_irq, even with SCL held low.
- R8: With enable and SCL-low timeout enabled and split mode off, the counter is held at tmo_reload while SCL is high. Each cycle SCL is low it counts up by one. Stepping past 0xFFFF sets tmo_irq. With reload 0xFFF0, this happens about 17 cycles after SCL goes low. SCL held high never sets tmo_irq.
- R9: In split mode, only the upper byte is held at its reload value while SCL is high, and the lower byte keeps running. The upper byte counts while SCL is low, and its overflow sets tmo_irq.
- R10: tmo_irq stays at 1 until tmo_clr is pulsed. A clear that coincides with a new overflow wins.
- R11: With slave inhibit at 1, slv_irq stays at 0 whatever slv_evt is. When the inhibit is 0, slv_irq follows slv_evt. mst_irq always follows mst_evt.
- R12: ext_hold outputs the stored extended-hold bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Raw SCL line level |
| sda_in | input | 1 | Raw SDA line level |
| tick_t0 | input | 1 | Tick source 0 (select 00) |
| tick_t1 | input | 1 | Tick source 1 (select 01) |
| tick_t2h | input | 1 | Tick source 2 (select 10) |
| tick_t2l | input | 1 | Tick source 3 (select 11) |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration write data |
| cfg_rdata | output | 8 | Configuration read-back including the busy bit |
| tmo_reload | input | 16 | Reload value for the SCL-low counter |
| tmo_split | input | 1 | Run the timeout counter as two byte halves |
| tmo_clr | input | 1 | Clear strobe for tmo_irq |
| tmo_irq | output | 1 | Sticky SCL-low timeout flag |
| slv_evt | input | 1 | Slave event request |
| mst_evt | input | 1 | Master event request |
| slv_irq | output | 1 | Gated slave interrupt |
| mst_irq | output | 1 | Master interrupt |
| start_det | output | 1 | One-cycle START pulse |
| stop_det | output | 1 | One-cycle STOP pulse |
| bus_busy | output | 1 | Transfer in progress |
| bus_free | output | 1 | Free-bus timeout reached |
| ext_hold | output | 1 | Extended SDA setup/hold enable |

## Verification
The assertions assume that SDA and SCL never change in the same cycle once synchronized. From this it follows that a START and a STOP never coincide, and that neither can coincide with the free-count completing. The bench moves only one line at each step and waits several cycles between steps. Tick strobes last one cycle and arrive only while the lines are steady, and tmo_clr is pulsed only after SCL has been raised.

// File: rtl/smon_pkg.sv
package smon_pkg;

  typedef struct packed {
    logic [1:0] sel;
    logic       fte;
    logic       tmoe;
    logic       ext;
    logic       busy;
    logic       inh;
    logic       en;
  } cfg_t;

  localparam int NSRC = 4;

  function automatic logic tick_pick(input logic [1:0] sel, input logic [NSRC-1:0] ticks);
    return ticks[sel];
  endfunction

endpackage

// File: rtl/smon_sync.sv
module smon_sync #(
  parameter int LINES  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] raw,
  output logic [LINES-1:0] synced
);
  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '1;
      else        chain <= {chain[STAGES-2:0], raw[g]};
    end
    assign synced[g] = chain[STAGES-1];
  end
endmodule

// File: rtl/smon_cond.sv
module smon_cond #(
  parameter int FREE_TICKS = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fte,
  input  logic tick,
  input  logic scl,
  input  logic sda,
  output logic start_det,
  output logic stop_det,
  output logic bus_busy,
  output logic bus_free
);
  localparam int LIM = FREE_TICKS + 1;
  localparam int FW  = $clog2(LIM + 1);
  localparam logic [FW-1:0] LIM_V = FW'(LIM);

  logic scl_p, sda_p;
  logic [FW-1:0] fcnt;
  logic idle, free_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 1'b1;
      sda_p <= 1'b1;
    end else begin
      scl_p <= scl;
      sda_p <= sda;
    end
  end

  assign start_det = en && scl && scl_p && sda_p && !sda;
  assign stop_det  = en && scl && scl_p && !sda_p && sda;
  assign idle      = en && fte && scl && sda;
  assign free_hit  = idle && tick && (fcnt == LIM_V - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                      fcnt <= '0;
    else if (!idle)                  fcnt <= '0;
    else if (tick && fcnt != LIM_V)  fcnt <= fcnt + 1'b1;
  end

  assign bus_free = (fcnt == LIM_V);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     bus_busy <= 1'b0;
    else if (!en)                   bus_busy <= 1'b0;
    else if (start_det)             bus_busy <= 1'b1;
    else if (stop_det || free_hit)  bus_busy <= 1'b0;
  end

  p_start_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> bus_busy);
  p_stop_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
    stop_det |=> !bus_busy);
  p_free_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_free |-> $past(scl && sda));
  p_free_notbusy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_free) |-> !bus_busy);
  p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !bus_busy);
endmodule

// File: rtl/smon_tmo.sv
module smon_tmo #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic             scl,
  input  logic             split,
  input  logic [CNT_W-1:0] reload,
  input  logic             clr,
  output logic             irq
);
  localparam int H = CNT_W / 2;

  function automatic logic [CNT_W:0] tmo_step(input logic [CNT_W-1:0] c,
                                                input logic [CNT_W-1:0] r,
                                                input logic sp, input logic hi);
    logic [CNT_W-H-1:0] uh;
    logic [H-1:0] ul;
    logic o;
    if (!sp) begin
      if (hi)      return {1'b0, r};
      else if (&c) return {1'b1, r};
      else         return {1'b0, c + 1'b1};
    end
    ul = (&c[H-1:0]) ? r[H-1:0] : c[H-1:0] + 1'b1;
    o  = 1'b0;
    if (hi)                  uh = r[CNT_W-1:H];
    else if (&c[CNT_W-1:H]) begin uh = r[CNT_W-1:H]; o = 1'b1; end
    else                     uh = c[CNT_W-1:H] + 1'b1;
    return {o, uh, ul};
  endfunction

  logic [CNT_W-1:0] cnt;
  logic [CNT_W:0]   nxt;
  logic             ovf;

  assign nxt = tmo_step(cnt, reload, split, scl);
  assign ovf = run && nxt[CNT_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cnt <= '0;
    else if (!run) cnt <= reload;
    else           cnt <= nxt[CNT_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   irq <= 1'b0;
    else if (clr) irq <= 1'b0;
    else if (ovf) irq <= 1'b1;
  end

  p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (run && scl && !split) |=> (cnt == $past(reload)));
  p_split_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && scl && split) |=> (cnt[CNT_W-1:H] == $past(reload[CNT_W-1:H])));
  p_clr_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> !irq);
  p_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !clr) |=> irq);
  p_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !irq) |=> !irq);
endmodule

// File: rtl/smbus_line_monitor.sv
module smbus_line_monitor
  import smon_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int FREE_TICKS  = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scl_in,
  input  logic             sda_in,
  input  logic             tick_t0,
  input  logic             tick_t1,
  input  logic             tick_t2h,
  input  logic             tick_t2l,
  input  logic             cfg_wr,
  input  logic [7:0]       cfg_wdata,
  output logic [7:0]       cfg_rdata,
  input  logic [CNT_W-1:0] tmo_reload,
  input  logic             tmo_split,
  input  logic             tmo_clr,
  output logic             tmo_irq,
  input  logic             slv_evt,
  input  logic             mst_evt,
  output logic             slv_irq,
  output logic             mst_irq,
  output logic             start_det,
  output logic             stop_det,
  output logic             bus_busy,
  output logic             bus_free,
  output logic             ext_hold
);
  cfg_t cfg_q, cfg_w;
  logic [1:0] lines_s;
  logic scl_s, sda_s, tick_sel;
  logic cfg_ro_unused;

  assign cfg_w         = cfg_t'(cfg_wdata);
  assign cfg_ro_unused = cfg_w.busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else if (cfg_wr) begin
      cfg_q      <= cfg_w;
      cfg_q.busy <= 1'b0;
    end
  end

  smon_sync #(.LINES(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .raw({scl_in, sda_in}), .synced(lines_s));
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  assign tick_sel = tick_pick(cfg_q.sel, {tick_t2l, tick_t2h, tick_t1, tick_t0});

  smon_cond #(.FREE_TICKS(FREE_TICKS)) u_cond (
    .clk(clk), .rst_n(rst_n), .en(cfg_q.en), .fte(cfg_q.fte), .tick(tick_sel),
    .scl(scl_s), .sda(sda_s), .start_det(start_det), .stop_det(stop_det),
    .bus_busy(bus_busy), .bus_free(bus_free));

  smon_tmo #(.CNT_W(CNT_W)) u_tmo (
    .clk(clk), .rst_n(rst_n), .run(cfg_q.en && cfg_q.tmoe), .scl(scl_s),
    .split(tmo_split), .reload(tmo_reload), .clr(tmo_clr), .irq(tmo_irq));

  assign slv_irq  = slv_evt && !cfg_q.inh;
  assign mst_irq  = mst_evt;
  assign ext_hold = cfg_q.ext;

  always_comb begin
    cfg_rdata    = cfg_q;
    cfg_rdata[2] = bus_busy;
  end

  p_events_exclusive_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !(start_det && stop_det));
  p_inhibit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.inh && slv_evt) |-> !slv_irq);
endmodule

// File: tb/sim_smbus_line_monitor.sv
`timescale 1ns/1ps
module sim_smbus_line_monitor;
  logic clk = 0, rst_n = 0;
  logic scl = 1, sda = 1;
  logic t0 = 0, t1 = 0, t2h = 0, t2l = 0;
  logic cfg_wr = 0;
  logic [7:0] cfg_wdata = 0, cfg_rdata;
  logic [15:0] reload = 16'h0000;
  logic split = 0, clr = 0, slv_evt = 0, mst_evt = 0;
  logic tmo_irq, slv_irq, mst_irq, start_det, stop_det, bus_busy, bus_free, ext_hold;
  int errors = 0, checks = 0, n_start = 0, n_stop = 0;

  always #4 clk = ~clk;

  smbus_line_monitor u0 (
    .clk(clk), .rst_n(rst_n), .scl_in(scl), .sda_in(sda),
    .tick_t0(t0), .tick_t1(t1), .tick_t2h(t2h), .tick_t2l(t2l),
    .cfg_wr(cfg_wr), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .tmo_reload(reload), .tmo_split(split), .tmo_clr(clr), .tmo_irq(tmo_irq),
    .slv_evt(slv_evt), .mst_evt(mst_evt), .slv_irq(slv_irq), .mst_irq(mst_irq),
    .start_det(start_det), .stop_det(stop_det), .bus_busy(bus_busy),
    .bus_free(bus_free), .ext_hold(ext_hold));

  always @(posedge clk) begin
    if (start_det) n_start++;
    if (stop_det)  n_stop++;
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wcfg(input logic [7:0] v);
    @(negedge clk); cfg_wr = 1; cfg_wdata = v;
    @(negedge clk); cfg_wr = 0;
    cyc(1);
  endtask

  task automatic pulse(input int src, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      case (src)
        0: t0 = 1; 1: t1 = 1; 2: t2h = 1; default: t2l = 1;
      endcase
      @(negedge clk); t0 = 0; t1 = 0; t2h = 0; t2l = 0;
    end
    cyc(3);
  endtask

  // START, then return both lines high without a STOP
  task automatic start_then_idle();
    sda = 0; cyc(5);
    scl = 0; cyc(5);
    sda = 1; cyc(5);
    scl = 1; cyc(5);
  endtask

  task automatic t_reset();
    check("R1 cfg", cfg_rdata, 8'h00);
    check("R1 busy", bus_busy, 0);
    check("R1 free", bus_free, 0);
    check("R1 irq", tmo_irq, 0);
    check("R1 ext", ext_hold, 0);
    check("R1 slv", slv_irq, 0);
  endtask

  task automatic t_cfg();
    wcfg(8'h08);
    check("R12 ext_hold", ext_hold, 1);
    check("R2 readback", cfg_rdata, 8'h08);
    wcfg(8'hFF);
    check("R2 busy read-only", cfg_rdata, 8'hFB);
    wcfg(8'h00);
    check("R12 ext cleared", ext_hold, 0);
  endtask

  task automatic t_start_stop();
    int s0, p0;
    wcfg(8'h01);
    s0 = n_start; p0 = n_stop;
    sda = 0; cyc(5);
    check("R3 start pulse", n_start - s0, 1);
    check("R3 busy set", bus_busy, 1);
    check("R2 busy bit", cfg_rdata[2], 1);
    scl = 0; cyc(5); sda = 1; cyc(5); scl = 1; cyc(5);
    check("R4 no stop with scl low", n_stop - p0, 0);
    check("R4 busy kept", bus_busy, 1);
    sda = 0; cyc(5);
    check("R3 repeated start", n_start - s0, 2);
    scl = 0; cyc(5); scl = 1; cyc(5);
    sda = 1; cyc(5);
    check("R4 stop pulse", n_stop - p0, 1);
    check("R4 busy cleared", bus_busy, 0);
  endtask

  task automatic t_free();
    wcfg(8'h21);
    start_then_idle();
    check("R5 busy before ticks", bus_busy, 1);
    pulse(0, 10);
    check("R5 busy after 10", bus_busy, 1);
    check("R5 free after 10", bus_free, 0);
    pulse(0, 1);
    check("R5 busy after 11", bus_busy, 0);
    check("R5 free after 11", bus_free, 1);
    scl = 0; cyc(5);
    check("R5 free drops on low", bus_free, 0);
    scl = 1; cyc(5);
    pulse(0, 10);
    check("R5 count restarted", bus_free, 0);
  endtask

  task automatic t_select();
    wcfg(8'hA1);
    start_then_idle();
    pulse(0, 12); pulse(1, 12); pulse(3, 12);
    check("R6 unselected ignored", bus_busy, 1);
    check("R6 unselected no free", bus_free, 0);
    pulse(2, 11);
    check("R6 select 10 frees", bus_busy, 0);
    wcfg(8'h61);
    start_then_idle();
    pulse(3, 11);
    check("R6 select 01 ignores t2l", bus_busy, 1);
    pulse(1, 11);
    check("R6 select 01 frees", bus_free, 1);
  endtask

  task automatic t_disable();
    int s0;
    wcfg(8'h10);
    reload = 16'hFFF0;
    s0 = n_start;
    sda = 0; cyc(5);
    check("R7 no start", n_start - s0, 0);
    check("R7 busy off", bus_busy, 0);
    scl = 0; cyc(40);
    check("R7 no timeout", tmo_irq, 0);
    sda = 1; cyc(3); scl = 1; cyc(5);
  endtask

  task automatic t_tmo();
    reload = 16'hFFF0; split = 0;
    wcfg(8'h11);
    cyc(60);
    check("R8 held high", tmo_irq, 0);
    scl = 0; cyc(10);
    check("R8 not yet", tmo_irq, 0);
    cyc(20);
    check("R8 overflow", tmo_irq, 1);
    scl = 1; cyc(20);
    check("R10 sticky", tmo_irq, 1);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; cyc(1);
    check("R10 cleared", tmo_irq, 0);
    cyc(100);
    check("R8 no irq scl high", tmo_irq, 0);
  endtask

  task automatic t_split();
    reload = 16'hFE00; split = 1;
    wcfg(8'h11);
    cyc(400);
    check("R9 high byte held", tmo_irq, 0);
    scl = 0; cyc(8);
    check("R9 high byte overflow", tmo_irq, 1);
    scl = 1; cyc(5);
    @(negedge clk); clr = 1; @(negedge clk); clr = 0; cyc(1);
    check("R10 split clear", tmo_irq, 0);
    split = 0;
  endtask

  task automatic t_irqs();
    wcfg(8'h01);
    slv_evt = 1; mst_evt = 0; #1;
    check("R11 slave passes", slv_irq, 1);
    check("R11 master idle", mst_irq, 0);
    wcfg(8'h03);
    #1;
    check("R11 slave inhibited", slv_irq, 0);
    mst_evt = 1; #1;
    check("R11 master passes", mst_irq, 1);
    slv_evt = 0; mst_evt = 0;
  endtask

  initial begin
    cyc(3); #1;
    t_reset();
    rst_n = 1;
    cyc(3);
    t_reset();
    t_cfg();
    t_start_stop();
    t_free();
    t_select();
    t_disable();
    t_tmo();
    t_split();
    t_irqs();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule